// File: doc/BRIEF.md
# Low-Frequency Watchdog with Keyed Reload Channels

This block is a watchdog that counts pulses of a slow-clock tick, typically one per 32.768 kHz period, delivered as a one-cycle enable in the system clock domain. Software loads a timeout limit, picks whether counting pauses while the CPU sleeps and while a debugger halts it, chooses which reload channels must be serviced, and fires a start task. Once started the watchdog runs until the next block reset, because no write can stop it.

To keep the system alive, software writes a fixed key to the reload register of every enabled channel. When all enabled channels have delivered the key since the last refresh, the counter reloads to the limit. If the count runs out, a timeout event is latched and can raise an interrupt. A system reset then follows a fixed two ticks later, and neither a refresh nor clearing the event prevents it.

Top module: `wdog_top`

Registers are addressed by word index. 0: start task, where writing bit0 = 1 starts the watchdog. 1: status, where bit0 = 1 means running. 2: timeout event, where bit0 reads as the flag and writing bit0 = 0 clears it. 3: interrupt-enable set, where writing bit0 = 1 enables. 4: interrupt-enable clear, where writing bit0 = 1 disables. Reads of 3 and 4 return the enable in bit0. 5: limit, 32 bits. 6: config, where bit0 = 1 keeps counting during sleep and bit1 = 1 keeps counting during halt. 7: channel enable, one bit per channel. 8 + k: reload register of channel k. Reset values: limit 0x0FFF, config 3, channel enable 1, everything else 0. The reload key is 0xC3A50F96.

## Requirements
- R1: After reset, status, event flag, irq_o and sys_rst_o all read 0, config reads 3 and channel enable reads 1.
- R2: A write of bit0 = 1 to the start register makes status read 1 on the next cycle. A start write with bit0 = 0 has no effect.
- R3: Once running, the watchdog stays running until rst_n, whatever is written.
- R4: After start, the event flag sets on the (limit + 1)th counted tick and not earlier.
- R5: Writing the key to an enabled channel's reload register reloads the count to the limit. A wrong value or a write to a disabled channel is ignored.
- R6: With several channels enabled, the count reloads only once every enabled channel has received the key since the previous reload.
- R7: With config bit0 = 0, ticks arriving while cpu_sleep_i = 1 are not counted. With bit0 = 1 they are counted.
- R8: With config bit1 = 0, ticks arriving while dbg_halt_i = 1 are not counted. With bit1 = 1 they are counted.
- R9: irq_o is high exactly while the event flag and the interrupt enable are both set. The enable is set and cleared through registers 3 and 4, and the flag is cleared by writing 0 to register 2.
- R10: sys_rst_o rises on the second raw tick after the expiring tick and then stays high until rst_n, even if the event is cleared or a key is written.
- R11: Writes to limit, config and channel enable are ignored while running. Readback keeps the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per slow-clock period |
| cpu_sleep_i | input | 1 | CPU is sleeping |
| dbg_halt_i | input | 1 | Debugger holds the CPU halted |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Timeout interrupt |
| sys_rst_o | output | 1 | System reset request |

## Verification
The assertions assume that tick_i is a single-cycle pulse and that a write lasts one cycle. They also assume that reset is held for at least one clock before any write. The bench drives every tick and write as a one-cycle pulse between falling edges and keeps ticks and register writes apart. As a result, a refresh never coincides with an expiring tick, and no ordering between the two is relied on.

// File: rtl/wdog_pkg.sv
// Shared definitions for the watchdog: state encoding and register word indices.
package wdog_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_EXP, ST_RST} wd_state_t;

    localparam int unsigned A_START   = 0;
    localparam int unsigned A_STAT    = 1;
    localparam int unsigned A_EVT     = 2;
    localparam int unsigned A_IEN_SET = 3;
    localparam int unsigned A_IEN_CLR = 4;
    localparam int unsigned A_LIMIT   = 5;
    localparam int unsigned A_CFG     = 6;
    localparam int unsigned A_CHEN    = 7;
    localparam int unsigned A_KEY0    = 8;
endpackage

// File: rtl/wdog_regs.sv
// Register file and bus decode of the watchdog.
// Holds limit, config, channel enables, interrupt enable and the timeout event.
// Assumes single-cycle writes; reads are combinational on bus_addr.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int unsigned NCH       = 4,
    parameter int unsigned ADDR_W    = 4,
    parameter logic [31:0] LIMIT_RST = 32'h0000_0FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              running,
    input  logic              expire,
    output logic              start_req,
    output logic [31:0]       crv,
    output logic              run_sleep,
    output logic              run_halt,
    output logic [NCH-1:0]    chen,
    output logic              irq
);
    logic [31:0]    crv_q;
    logic [1:0]     cfg_q;
    logic [NCH-1:0] chen_q;
    logic           ien_q;
    logic           evt_q;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned idx);
        return a == ADDR_W'(idx);
    endfunction

    // Start task pulse: a write of bit0 = 1 to the start register
    assign start_req = bus_wr && hit(bus_addr, A_START) && bus_wdata[0];

    // Configuration registers, frozen while the watchdog runs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crv_q  <= LIMIT_RST;
            cfg_q  <= 2'b11;
            chen_q <= NCH'(1);
        end else if (bus_wr && !running) begin
            if (hit(bus_addr, A_LIMIT)) crv_q  <= bus_wdata;
            if (hit(bus_addr, A_CFG))   cfg_q  <= bus_wdata[1:0];
            if (hit(bus_addr, A_CHEN))  chen_q <= bus_wdata[NCH-1:0];
        end
    end

    // Interrupt enable: set and clear through separate registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q <= 1'b0;
        end else if (bus_wr && bus_wdata[0]) begin
            if (hit(bus_addr, A_IEN_SET))      ien_q <= 1'b1;
            else if (hit(bus_addr, A_IEN_CLR)) ien_q <= 1'b0;
        end
    end

    // Timeout event flag: set on expiry (wins), cleared by writing 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= 1'b0;
        end else if (expire) begin
            evt_q <= 1'b1;
        end else if (bus_wr && hit(bus_addr, A_EVT) && !bus_wdata[0]) begin
            evt_q <= 1'b0;
        end
    end

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (hit(bus_addr, A_STAT))         bus_rdata[0] = running;
        else if (hit(bus_addr, A_EVT))     bus_rdata[0] = evt_q;
        else if (hit(bus_addr, A_IEN_SET) || hit(bus_addr, A_IEN_CLR)) bus_rdata[0] = ien_q;
        else if (hit(bus_addr, A_LIMIT))   bus_rdata = crv_q;
        else if (hit(bus_addr, A_CFG))     bus_rdata[1:0] = cfg_q;
        else if (hit(bus_addr, A_CHEN))    bus_rdata[NCH-1:0] = chen_q;
    end

    assign crv       = crv_q;
    assign run_sleep = cfg_q[0];
    assign run_halt  = cfg_q[1];
    assign chen      = chen_q;
    assign irq       = evt_q && ien_q;

    // R11
    cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> ($stable(crv_q) && $stable(cfg_q) && $stable(chen_q)));

    // R9
    evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(evt_q) |-> $past(bus_wr && hit(bus_addr, A_EVT) && !bus_wdata[0]));
endmodule

// File: rtl/wdog_reload.sv
// Reload-request collector: records which enabled channels received the key
// and raises reload_acc once all enabled channels have done so.
// Assumes chen is stable while armed (the register file locks it).
module wdog_reload
    import wdog_pkg::*;
#(
    parameter int unsigned NCH        = 4,
    parameter int unsigned ADDR_W     = 4,
    parameter logic [31:0] RELOAD_KEY = 32'hC3A5_0F96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [NCH-1:0]    chen,
    input  logic              armed,
    output logic              reload_acc
);
    logic [NCH-1:0] hit_vec;
    logic [NCH-1:0] pend_q;
    logic [NCH-1:0] seen;
    logic           key_ok;

    assign key_ok = bus_wr && armed && (bus_wdata == RELOAD_KEY);

    // One decoder per reload channel
    for (genvar k = 0; k < NCH; k++) begin : g_ch
        assign hit_vec[k] = key_ok && chen[k] &&
                            (bus_addr == ADDR_W'(A_KEY0 + k));
    end

    assign seen       = pend_q | hit_vec;
    assign reload_acc = (|hit_vec) && ((seen & chen) == chen);

    // Pending record: accumulate keyed channels, clear on an accepted reload
    always_ff @(posedge clk) begin
        if (!rst_n || !armed)  pend_q <= '0;
        else if (reload_acc)   pend_q <= '0;
        else                   pend_q <= seen;
    end

    // R6
    pend_partial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload_acc |=> (pend_q == '0));
endmodule

// File: rtl/wdog_core.sv
// Counter and expiry sequencer. Counts qualified slow ticks down from the
// limit, flags expiry, then asserts the system reset RST_DELAY raw ticks later.
// Assumes tick_i is a single-cycle pulse.
module wdog_core
    import wdog_pkg::*;
#(
    parameter int unsigned RST_DELAY = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_req,
    input  logic        reload_acc,
    input  logic        tick_i,
    input  logic        cpu_sleep_i,
    input  logic        dbg_halt_i,
    input  logic        run_sleep,
    input  logic        run_halt,
    input  logic [31:0] crv,
    output logic        running,
    output logic        armed,
    output logic        expire,
    output logic        sys_rst
);
    localparam int unsigned DLY_W = $clog2(RST_DELAY + 1);

    wd_state_t        state;
    logic [31:0]      cnt;
    logic [DLY_W-1:0] dly;
    logic             cnt_tick;

    // Qualified tick: dropped while paused by sleep or halt
    assign cnt_tick = tick_i && !(cpu_sleep_i && !run_sleep)
                             && !(dbg_halt_i && !run_halt);

    assign running = (state != ST_IDLE);
    assign armed   = (state == ST_RUN);
    assign expire  = armed && cnt_tick && (cnt == '0) && !reload_acc;
    assign sys_rst = (state == ST_RST);

    // State, down-counter and reset-delay sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            dly   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start_req) begin
                    state <= ST_RUN;
                    cnt   <= crv;
                end
                ST_RUN: begin
                    if (reload_acc) begin
                        cnt <= crv;
                    end else if (cnt_tick) begin
                        if (cnt == '0) begin
                            state <= ST_EXP;
                            dly   <= '0;
                        end else begin
                            cnt <= cnt - 32'd1;
                        end
                    end
                end
                ST_EXP: if (tick_i) begin
                    dly <= dly + DLY_W'(1);
                    if (dly == DLY_W'(RST_DELAY - 1)) state <= ST_RST;
                end
                default: state <= ST_RST;
            endcase
        end
    end

    // R3
    run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running);

    // R7
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !cnt_tick && !reload_acc) |=> $stable(cnt));

    // R10
    rst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |=> sys_rst);
endmodule

// File: rtl/wdog_top.sv
// Top level of the slow-clock watchdog: register file, reload collector and
// counter core. Assumes tick_i is synchronous to clk, one cycle wide.
module wdog_top #(
    parameter int unsigned NCH        = 4,
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned RST_DELAY  = 2,
    parameter logic [31:0] RELOAD_KEY = 32'hC3A5_0F96,
    parameter logic [31:0] LIMIT_RST  = 32'h0000_0FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              cpu_sleep_i,
    input  logic              dbg_halt_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              irq_o,
    output logic              sys_rst_o
);
    logic           start_req, running, armed, expire, reload_acc;
    logic           run_sleep, run_halt;
    logic [31:0]    crv;
    logic [NCH-1:0] chen;

    wdog_regs #(.NCH(NCH), .ADDR_W(ADDR_W), .LIMIT_RST(LIMIT_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr_i), .bus_addr(bus_addr_i),
        .bus_wdata(bus_wdata_i), .bus_rdata(bus_rdata_o), .running(running),
        .expire(expire), .start_req(start_req), .crv(crv),
        .run_sleep(run_sleep), .run_halt(run_halt), .chen(chen), .irq(irq_o)
    );

    wdog_reload #(.NCH(NCH), .ADDR_W(ADDR_W), .RELOAD_KEY(RELOAD_KEY)) u_reload (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr_i), .bus_addr(bus_addr_i),
        .bus_wdata(bus_wdata_i), .chen(chen), .armed(armed),
        .reload_acc(reload_acc)
    );

    wdog_core #(.RST_DELAY(RST_DELAY)) u_core (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .reload_acc(reload_acc),
        .tick_i(tick_i), .cpu_sleep_i(cpu_sleep_i), .dbg_halt_i(dbg_halt_i),
        .run_sleep(run_sleep), .run_halt(run_halt), .crv(crv),
        .running(running), .armed(armed), .expire(expire), .sys_rst(sys_rst_o)
    );

    // R10
    rst_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |-> $past(tick_i));
endmodule

// File: tb/tb_wdog_top.sv
`timescale 1ns/100ps
module tb_wdog_top;
    localparam logic [31:0] KEY = 32'hC3A5_0F96;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0, cpu_sleep_i = 1'b0, dbg_halt_i = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic [3:0]  bus_addr_i = '0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic        irq_o, sys_rst_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        int          sel;   // 0 read data, 1 irq_o, 2 sys_rst_o
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sbq[$];
    event  smp_ev;

    always #2.5 clk = ~clk;

    wdog_top dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cpu_sleep_i(cpu_sleep_i),
        .dbg_halt_i(dbg_halt_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .irq_o(irq_o),
        .sys_rst_o(sys_rst_o)
    );

    // Monitor: pops expected items and compares them with the ports
    initial begin
        forever begin
            @(smp_ev);
            #1;
            while (sbq.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sbq.pop_front();
                act = (it.sel == 0) ? bus_rdata_o :
                      (it.sel == 1) ? {31'd0, irq_o} : {31'd0, sys_rst_o};
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic push(input int sel, input logic [3:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_addr_i = a;
        it.sel = sel; it.exp = e; it.tag = tag;
        sbq.push_back(it);
        -> smp_ev;
        wait (sbq.size() == 0);
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        push(0, a, e, tag);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_wr_i = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        cpu_sleep_i = 1'b0; dbg_halt_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic arm(input logic [31:0] lim, input logic [31:0] cfg, input logic [31:0] ch);
        do_reset();
        wr(5, lim); wr(6, cfg); wr(7, ch); wr(0, 32'd1);
    endtask

    initial begin
        // Run 1: reset state, start, locking, pauses, expiry, reset delay
        do_reset();
        rd(1, 0, "R1 status");
        rd(2, 0, "R1 event");
        rd(6, 3, "R1 config");
        rd(7, 1, "R1 chen");
        push(1, 0, 0, "R1 irq");
        push(2, 0, 0, "R1 sysrst");
        wr(5, 3); wr(6, 0); wr(7, 1);
        rd(5, 3, "R11 limit idle write");
        wr(0, 32'd0);
        rd(1, 0, "R2 start with 0");
        wr(0, 32'd1);
        rd(1, 1, "R2 running");
        wr(5, 9); wr(6, 3); wr(7, 3);
        rd(5, 3, "R11 limit locked");
        rd(6, 0, "R11 config locked");
        rd(7, 1, "R11 chen locked");
        wr(0, 32'd0); wr(2, 32'd0);
        rd(1, 1, "R3 still running");
        tick(3);
        rd(2, 0, "R4 no event before limit+1");
        cpu_sleep_i = 1'b1; tick(2); cpu_sleep_i = 1'b0;
        rd(2, 0, "R7 paused in sleep");
        dbg_halt_i = 1'b1; tick(2); dbg_halt_i = 1'b0;
        rd(2, 0, "R8 paused in halt");
        tick(1);
        rd(2, 1, "R4 event at limit+1");
        push(1, 0, 0, "R9 irq masked");
        wr(3, 32'd1);
        push(1, 0, 1, "R9 irq enabled");
        tick(1);
        push(2, 0, 0, "R10 one tick after expiry");
        wr(2, 32'd0);
        rd(2, 0, "R9 event cleared");
        push(1, 0, 0, "R9 irq drops");
        wr(8, KEY);
        tick(1);
        push(2, 0, 1, "R10 reset after two ticks");
        tick(2);
        push(2, 0, 1, "R10 reset stays");

        // Run 2: counting through sleep/halt when allowed, single channel reload
        arm(2, 3, 1);
        cpu_sleep_i = 1'b1; dbg_halt_i = 1'b1;
        tick(2);
        wr(8, KEY);
        tick(2);
        rd(2, 0, "R5 key reloaded");
        wr(8, 32'h1234_5678);
        wr(9, KEY);
        tick(1);
        rd(2, 1, "R7 R8 counted while allowed; R5 bad key ignored");

        // Run 3: two channels, only one keyed
        arm(2, 3, 32'h5);
        tick(2);
        wr(8, KEY);
        tick(1);
        rd(2, 1, "R6 partial keys no reload");

        // Run 4: two channels both keyed, then enable clear
        arm(2, 3, 32'h5);
        tick(2);
        wr(10, KEY);
        wr(8, KEY);
        tick(2);
        rd(2, 0, "R6 all channels reload");
        wr(3, 32'd1); wr(4, 32'd1);
        rd(3, 0, "R9 enable cleared");
        tick(1);
        rd(2, 1, "R6 expiry after reload");
        push(1, 0, 0, "R9 irq off when disabled");
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog for a hung run
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule